// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is the serial front end of a temperature monitor. It watches an oversampled two-wire bus (clock and open-drain data), answers to a 7-bit device address whose upper four bits are fixed at `1001` and whose lower three come from strap pins, and gives access to four 16-bit registers through a 2-bit pointer. The pointer selects the temperature reading, the configuration byte, the hysteresis limit or the over-temperature limit. The byte that follows a write address is either a pointer byte or one of three command opcodes: recall, copy and soft reset. Recall and copy raise a request strobe toward the nonvolatile store. Soft reset raises a strobe toward the rest of the chip.

Register data leaves on a write strobe with select and data, and arrives through a combinational read port that follows the pointer. There is no back-pressure on either side, because a two-wire slave cannot stall a byte in flight. The register file must take `wr_en_o` in the cycle it is raised. `rd_data_i` must be valid for the current `rd_sel_o` at all times, and it is captured once, when a read address is acknowledged. A watchdog releases the data line if the slave itself has held it low for `TIMEOUT_CYC` system clocks, and then returns the interface to idle.

Top module: `tsense_bus_slave`

## Requirements
- R1: An address byte whose upper seven bits equal `1001` followed by `addr_sel_i[2:0]` is acknowledged (bit 0 set means read, clear means write). Any other address is not acknowledged, and the slave stays silent until the next START.
- R2: A pointer byte has bits 7:2 at zero, and bits 1:0 select the register: 00 temperature, 01 configuration, 10 hysteresis limit, 11 over-temperature limit. The pointer is 00 after reset. It is kept across transactions until it is rewritten. A non-command byte with any of bits 7:2 set is not acknowledged and leaves the pointer unchanged.
- R3: After pointer 01, one acknowledged data byte yields one `wr_en_o` pulse with `wr_data_o = {8'h00, 1'b0, byte[6:0]}`, because bit 7 is a read-only busy flag. After pointer 10 or 11, the MS byte and then the LS byte are acknowledged, and one pulse carries `{MS, LS}` after the second byte. A limit write cut short by STOP produces no pulse. Any further data byte is not acknowledged.
- R4: The temperature register is read-only. A data byte after pointer 00 is not acknowledged and produces no write.
- R5: A read sends MSB first. Pointers 00, 10 and 11 return `rd_data_i[15:8]` and then `rd_data_i[7:0]` if the master acknowledges the first byte. Pointer 01 returns only `rd_data_i[7:0]`. After the last byte, or after a master NACK, the slave releases the data line, so further bytes read as 8'hFF until STOP or START.
- R6: Each acknowledged read address gives exactly one single-cycle `rd_strobe_o` pulse.
- R7: Byte 8'hB8 after a write address is acknowledged and pulses `recall_req_o` once. Byte 8'h48 is acknowledged and pulses `copy_req_o` once. Strobes never coincide.
- R8: Byte 8'h54 after a write address is not acknowledged. It pulses `soft_rst_o` once and returns the pointer to 00.
- R9: A falling data line while the clock is high is a START. A rising data line while the clock is high is a STOP. Either one aborts any transfer in progress. A START inside a byte begins a fresh address phase, and a repeated START after a pointer write reads from the new pointer.
- R10: If the slave holds the data line low for `TIMEOUT_CYC` consecutive clocks, it releases the line and goes idle. A master holding the line low never triggers this.
- R11: The slave starts pulling the data line low only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| addr_sel_i | input | 3 | Low three bits of the device address |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| rd_sel_o | output | 2 | Current pointer, selects the register on rd_data_i |
| rd_data_i | input | 16 | Contents of the selected register |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_sel_o | output | 2 | Register written by wr_en_o |
| wr_data_o | output | 16 | Data written by wr_en_o |
| rd_strobe_o | output | 1 | One-cycle pulse when a read is accepted |
| copy_req_o | output | 1 | One-cycle copy-to-nonvolatile request |
| recall_req_o | output | 1 | One-cycle recall-from-nonvolatile request |
| soft_rst_o | output | 1 | One-cycle soft reset request |

## Verification
A corrupted pointer is visible on the very next read. It shows as the wrong register's bytes, or as a missing second byte when the pointer lands on configuration. A bit counter out of step shifts the acknowledge slot, so the master sees a NACK, or a byte rotated by one bit, within the same byte. A wrong per-register length shows up inside that transaction as an extra or missing write strobe, or as a stray 8'hFF. A stuck drive shows up as the watchdog release after `TIMEOUT_CYC` clocks.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WB0, ST_WB1, ST_RD, ST_DONE
  } tsb_state_e;

  localparam logic [1:0] PTR_TEMP = 2'b00;
  localparam logic [1:0] PTR_CFG  = 2'b01;
  localparam logic [1:0] PTR_HYST = 2'b10;
  localparam logic [1:0] PTR_OVER = 2'b11;

  localparam logic [7:0] OP_RECALL  = 8'hB8;
  localparam logic [7:0] OP_COPY    = 8'h48;
  localparam logic [7:0] OP_SOFTRST = 8'h54;

  localparam logic [3:0] DEV_PREFIX = 4'b1001;
endpackage

// File: rtl/tsb_line_sync.sv
module tsb_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], raw_i[g]};
    end
    assign lvl_o[g]  = pipe[STAGES-1];
    assign rise_o[g] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall_o[g] = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/tsb_hold_watchdog.sv
module tsb_hold_watchdog #(
  parameter int TIMEOUT_CYC = 7_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic expire_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] run_q;

  assign expire_o = hold_i && (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_q <= '0;
    else if (!hold_i || expire_o) run_q <= '0;
    else                          run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/tsense_bus_slave.sv
module tsense_bus_slave
  import tsb_pkg::*;
#(
  parameter int TIMEOUT_CYC = 7_500_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  addr_sel_i,
  output logic        sda_oe_o,
  output logic [1:0]  rd_sel_o,
  input  logic [15:0] rd_data_i,
  output logic        wr_en_o,
  output logic [1:0]  wr_sel_o,
  output logic [15:0] wr_data_o,
  output logic        rd_strobe_o,
  output logic        copy_req_o,
  output logic        recall_req_o,
  output logic        soft_rst_o
);
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;

  logic [1:0] lvl, rise, fall;
  logic       start_det, stop_det, wd_expire;

  tsb_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({sda_i, scl_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  // Bus conditions: data edge while the clock is high
  assign start_det = fall[LINE_SDA] & lvl[LINE_SCL];
  assign stop_det  = rise[LINE_SDA] & lvl[LINE_SCL];

  tsb_hold_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
    .clk(clk), .rst_n(rst_n), .hold_i(sda_oe_o), .expire_o(wd_expire)
  );

  tsb_state_e state, nxt_q;
  logic [3:0]  cnt;
  logic [7:0]  sh, hi_q, tx_byte;
  logic [15:0] rd_buf;
  logic [1:0]  ptr;
  logic        ack_q, mack_q, byte_idx, oe;
  logic [7:0]  rx_byte, first_byte;
  logic [2:0]  tx_idx;
  logic        rx_state;

  assign rx_byte    = {sh[6:0], lvl[LINE_SDA]};
  assign first_byte = (ptr == PTR_CFG) ? rd_buf[7:0] : rd_buf[15:8];
  assign tx_idx     = 3'd7 - cnt[2:0];
  assign rx_state   = (state == ST_ADDR) || (state == ST_CMD) ||
                      (state == ST_WB0)  || (state == ST_WB1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  nxt_q <= ST_DONE;  cnt <= '0;
      sh <= '0;  hi_q <= '0;  tx_byte <= '0;  rd_buf <= '0;
      ptr <= PTR_TEMP;  ack_q <= 1'b0;  mack_q <= 1'b0;  byte_idx <= 1'b0;
      oe <= 1'b0;  wr_en_o <= 1'b0;  wr_sel_o <= '0;  wr_data_o <= '0;
      rd_strobe_o <= 1'b0;  copy_req_o <= 1'b0;
      recall_req_o <= 1'b0;  soft_rst_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;  rd_strobe_o <= 1'b0;
      copy_req_o <= 1'b0;  recall_req_o <= 1'b0;  soft_rst_o <= 1'b0;
      if (wd_expire) begin
        state <= ST_IDLE;  oe <= 1'b0;
      end else if (start_det) begin
        state <= ST_ADDR;  cnt <= '0;  oe <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;  oe <= 1'b0;
      end else if (rise[LINE_SCL]) begin
        if (rx_state && cnt < 4'd8) begin
          sh  <= rx_byte;
          cnt <= cnt + 1'b1;
          if (cnt == 4'd7) begin
            ack_q <= 1'b0;
            nxt_q <= ST_DONE;
            case (state)
              ST_ADDR: if (rx_byte[7:1] == {DEV_PREFIX, addr_sel_i}) begin
                ack_q <= 1'b1;
                if (rx_byte[0]) begin
                  nxt_q <= ST_RD;  rd_buf <= rd_data_i;  rd_strobe_o <= 1'b1;
                end else begin
                  nxt_q <= ST_CMD;
                end
              end
              ST_CMD: begin
                if (rx_byte == OP_RECALL) begin
                  ack_q <= 1'b1;  recall_req_o <= 1'b1;
                end else if (rx_byte == OP_COPY) begin
                  ack_q <= 1'b1;  copy_req_o <= 1'b1;
                end else if (rx_byte == OP_SOFTRST) begin
                  soft_rst_o <= 1'b1;  ptr <= PTR_TEMP;
                end else if (rx_byte[7:2] == 6'd0) begin
                  ack_q <= 1'b1;
                  ptr   <= rx_byte[1:0];
                  nxt_q <= (rx_byte[1:0] == PTR_TEMP) ? ST_DONE : ST_WB0;
                end
              end
              ST_WB0: begin
                ack_q <= 1'b1;
                if (ptr == PTR_CFG) begin
                  wr_en_o <= 1'b1;  wr_sel_o <= ptr;
                  wr_data_o <= {8'h00, 1'b0, rx_byte[6:0]};
                end else begin
                  hi_q <= rx_byte;  nxt_q <= ST_WB1;
                end
              end
              ST_WB1: begin
                ack_q <= 1'b1;  wr_en_o <= 1'b1;  wr_sel_o <= ptr;
                wr_data_o <= {hi_q, rx_byte};
              end
              default: ;
            endcase
          end
        end else if (state == ST_RD) begin
          if (cnt < 4'd8) cnt <= cnt + 1'b1;
          else if (cnt == 4'd8) begin
            mack_q <= ~lvl[LINE_SDA];  cnt <= 4'd9;
          end
        end
      end else if (fall[LINE_SCL]) begin
        if (rx_state) begin
          if (cnt == 4'd8) begin
            if (ack_q) begin
              oe <= 1'b1;  cnt <= 4'd9;
            end else begin
              state <= ST_DONE;  oe <= 1'b0;
            end
          end else if (cnt == 4'd9) begin
            oe <= 1'b0;  cnt <= '0;  state <= nxt_q;
            if (nxt_q == ST_RD) begin
              tx_byte <= first_byte;  byte_idx <= 1'b0;  oe <= ~first_byte[7];
            end
          end
        end else if (state == ST_RD) begin
          if (cnt >= 4'd1 && cnt <= 4'd7) begin
            oe <= ~tx_byte[tx_idx];
          end else if (cnt == 4'd8) begin
            oe <= 1'b0;
          end else if (cnt == 4'd9) begin
            if (mack_q && !byte_idx && ptr != PTR_CFG) begin
              tx_byte <= rd_buf[7:0];  byte_idx <= 1'b1;
              oe <= ~rd_buf[7];  cnt <= '0;
            end else begin
              state <= ST_DONE;  oe <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign sda_oe_o = oe;
  assign rd_sel_o = ptr;
endmodule

// File: rtl/tsb_checker.sv
module tsb_checker #(
  parameter int TIMEOUT_CYC = 7_500_000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe_o,
  input logic [1:0]  rd_sel_o,
  input logic        wr_en_o,
  input logic [1:0]  wr_sel_o,
  input logic [15:0] wr_data_o,
  input logic        rd_strobe_o,
  input logic        copy_req_o,
  input logic        recall_req_o,
  input logic        soft_rst_o
);
  int unsigned hold_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_run <= 0;
    else if (sda_oe_o) hold_run <= hold_run + 1;
    else               hold_run <= 0;
  end

  assert_hold_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (hold_run < TIMEOUT_CYC));

  assert_drive_clk_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en_o, rd_strobe_o, copy_req_o, recall_req_o, soft_rst_o}));

  assert_softrst_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (rd_sel_o == 2'b00) && !sda_oe_o);

  assert_temp_readonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_sel_o != 2'b00));

  assert_cfg_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_sel_o == 2'b01) |-> (wr_data_o[15:7] == 9'd0));

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_o |=> !rd_strobe_o);
endmodule

bind tsense_bus_slave tsb_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tsb_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .rd_sel_o(rd_sel_o), .wr_en_o(wr_en_o), .wr_sel_o(wr_sel_o),
  .wr_data_o(wr_data_o), .rd_strobe_o(rd_strobe_o), .copy_req_o(copy_req_o),
  .recall_req_o(recall_req_o), .soft_rst_o(soft_rst_o)
);

// File: tb/tb_tsense_bus_slave.sv
`timescale 1ns/1ps
module tb_tsense_bus_slave;
  localparam int TO_CYC = 400;
  localparam int H      = 16;
  localparam logic [7:0] A_WR = 8'h94, A_RD = 8'h95, A_BAD = 8'h92;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] addr_sel = 3'b010;
  logic sda_oe, wr_en, rd_strobe, copy_req, recall_req, soft_rst;
  logic [1:0] rd_sel, wr_sel;
  logic [15:0] wr_data, rd_data;
  logic [15:0] regs [4];
  wire sda_line = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  tsense_bus_slave #(.TIMEOUT_CYC(TO_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_oe_o(sda_oe), .rd_sel_o(rd_sel),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_sel_o(wr_sel),
    .wr_data_o(wr_data), .rd_strobe_o(rd_strobe), .copy_req_o(copy_req),
    .recall_req_o(recall_req), .soft_rst_o(soft_rst)
  );

  // Register file model on the bench side
  assign rd_data = regs[rd_sel];
  initial begin
    regs[0] = 16'h1910; regs[1] = 16'h0000; regs[2] = 16'h4B00; regs[3] = 16'h5000;
  end
  always @(posedge clk) if (wr_en) regs[wr_sel] <= wr_data;

  int n_cmp = 0, n_bad = 0;

  task automatic check_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard: kind 0 write, 1 copy, 2 recall, 3 soft reset, 4 read strobe
  typedef struct { int kind; logic [1:0] sel; logic [15:0] data; string req; } ev_t;
  ev_t expq[$];

  task automatic expect_ev(input int kind, input logic [1:0] sel, input logic [15:0] data, input string req);
    ev_t e;
    e.kind = kind; e.sel = sel; e.data = data; e.req = req;
    expq.push_back(e);
  endtask

  task automatic observe(input int kind, input logic [1:0] sel, input logic [15:0] data);
    ev_t e;
    if (expq.size() == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard unexpected event actual=%0d expected=none", kind);
    end else begin
      e = expq.pop_front();
      check_eq({e.req, " event kind"}, 16'(kind), 16'(e.kind));
      if (kind == 0) check_eq({e.req, " write"}, {sel, 14'd0} ^ data, {e.sel, 14'd0} ^ e.data);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wr_en)      observe(0, wr_sel, wr_data);
    if (copy_req)   observe(1, 2'b00, 16'h0);
    if (recall_req) observe(2, 2'b00, 16'h0);
    if (soft_rst)   observe(3, 2'b00, 16'h0);
    if (rd_strobe)  observe(4, 2'b00, 16'h0);
  end

  task automatic wait_h(); repeat (H) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_h(); m_scl = 1'b1; wait_h();
    m_sda = 1'b0; wait_h(); m_scl = 1'b0; wait_h();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_h(); m_scl = 1'b1; wait_h(); m_sda = 1'b1; wait_h();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_h(); m_scl = 1'b1; wait_h(); m_scl = 1'b0;
    end
    m_sda = 1'b1; wait_h(); m_scl = 1'b1; wait_h();
    ack = ~sda_line; m_scl = 1'b0; wait_h();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_h(); m_scl = 1'b1; wait_h(); b[i] = sda_line; m_scl = 1'b0;
    end
    m_sda = ~mack; wait_h(); m_scl = 1'b1; wait_h(); m_scl = 1'b0; wait_h();
    m_sda = 1'b1;
  endtask

  task automatic read_two(input string req, input logic [15:0] exp);
    logic a; logic [7:0] hi, lo;
    expect_ev(4, 2'b00, 16'h0, "R6");
    bus_start(); send_byte(A_RD, a);
    check_eq({req, " R1 read address ack"}, 16'(a), 16'd1);
    recv_byte(1'b1, hi); recv_byte(1'b0, lo);
    check_eq({req, " R5 two-byte read"}, {hi, lo}, exp);
    bus_stop();
  endtask

  task automatic write_bytes(input logic [7:0] b0, input logic [7:0] b1, input int n, input string req,
                             input logic [2:0] exp_acks);
    logic a0, a1, a2;
    bus_start(); send_byte(A_WR, a0);
    send_byte(b0, a1);
    a2 = 1'b0;
    if (n > 1) send_byte(b1, a2);
    check_eq({req, " acks"}, 16'({a0, a1, a2}), 16'(exp_acks));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic a, a2; logic [7:0] b, b2;
    repeat (5) @(negedge clk);
    check_eq("R10 data line released after reset", 16'(sda_oe), 16'd0);
    check_eq("R2 pointer default temperature", 16'(rd_sel), 16'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    read_two("R2 default pointer", 16'h1910);

    // R1: foreign address ignored
    bus_start(); send_byte(A_BAD, a);
    check_eq("R1 foreign address nack", 16'(a), 16'd0);
    bus_stop();

    // R3: configuration write, bit 7 stripped; R9 repeated start read
    expect_ev(0, 2'b01, 16'h0065, "R3 cfg write");
    write_bytes(8'h01, 8'hE5, 2, "R3 cfg", 3'b111);
    expect_ev(4, 2'b00, 16'h0, "R6");
    bus_start(); send_byte(A_RD, a);
    recv_byte(1'b1, b); recv_byte(1'b0, b2);
    check_eq("R9 R5 cfg one byte then release", {b, b2}, 16'h65FF);
    bus_stop();

    // R3: over-temperature limit write, two bytes MS first
    expect_ev(0, 2'b11, 16'h5A80, "R3 limit write");
    write_bytes(8'h03, 8'h5A, 2, "R3 limit hi", 3'b111);
    send_byte(8'h80, a);
    check_eq("R3 limit lo ack", 16'(a), 16'd1);
    send_byte(8'h33, a);
    check_eq("R3 extra byte nack", 16'(a), 16'd0);
    bus_stop();
    read_two("R2 pointer after write", 16'h5A80);
    read_two("R2 pointer persists", 16'h5A80);

    // R5: master NACK after first byte ends the transfer
    expect_ev(4, 2'b00, 16'h0, "R6");
    bus_start(); send_byte(A_RD, a);
    recv_byte(1'b0, b); recv_byte(1'b0, b2);
    check_eq("R5 nack then released", {b, b2}, 16'h5AFF);
    bus_stop();

    // R2: invalid pointer byte
    write_bytes(8'h07, 8'h00, 1, "R2 bad pointer", 3'b100);
    bus_stop();
    read_two("R2 pointer unchanged", 16'h5A80);

    // R3: limit write cut short produces no write
    write_bytes(8'h02, 8'h11, 2, "R3 partial", 3'b111);
    bus_stop();
    read_two("R3 hysteresis unchanged", 16'h4B00);

    // R4: temperature read-only
    write_bytes(8'h00, 8'h12, 2, "R4 temp write nack", 3'b110);
    bus_stop();
    read_two("R4 temperature intact", 16'h1910);

    // R7: recall and copy
    expect_ev(2, 2'b00, 16'h0, "R7 recall");
    write_bytes(OP_B8(), 8'h00, 2, "R7 recall ack, next nack", 3'b110);
    bus_stop();
    expect_ev(1, 2'b00, 16'h0, "R7 copy");
    write_bytes(8'h48, 8'h00, 1, "R7 copy ack", 3'b110);
    bus_stop();

    // R8: soft reset returns pointer to temperature, no ack
    write_bytes(8'h01, 8'h00, 1, "R8 set pointer cfg", 3'b110);
    bus_stop();
    check_eq("R2 pointer now cfg", 16'(rd_sel), 16'd1);
    expect_ev(3, 2'b00, 16'h0, "R8 soft reset");
    write_bytes(8'h54, 8'h00, 1, "R8 soft reset nack", 3'b100);
    bus_stop();
    read_two("R8 pointer back to temp", 16'h1910);

    // R9: START inside a byte aborts it
    bus_start();
    for (int i = 7; i >= 4; i--) begin
      m_sda = A_WR[i]; wait_h(); m_scl = 1'b1; wait_h(); m_scl = 1'b0;
    end
    read_two("R9 abort by start", 16'h1910);

    // R10: master holding the data line low has no effect
    expect_ev(4, 2'b00, 16'h0, "R6");
    bus_start(); m_sda = 1'b0; repeat (3 * TO_CYC) @(negedge clk);
    send_byte(A_RD, a);
    recv_byte(1'b1, b); recv_byte(1'b0, b2);
    check_eq("R10 master hold ignored", {7'd0, a, b}, {7'd0, 1'b1, 8'h19});
    bus_stop();

    // R10: slave hold released by the watchdog
    expect_ev(4, 2'b00, 16'h0, "R6");
    bus_start(); send_byte(A_RD, a2);
    check_eq("R10 slave drives first bit low", 16'(sda_line), 16'd0);
    repeat (TO_CYC + 20) @(negedge clk);
    check_eq("R10 line released after timeout", 16'(sda_line), 16'd1);
    check_eq("R11 data line idle while clock low", 16'(sda_oe), 16'd0);
    bus_stop();
    read_two("R10 recovered", 16'h1910);

    repeat (20) @(negedge clk);
    check_eq("scoreboard drained", 16'(expq.size()), 16'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic [7:0] OP_B8();
    return 8'hB8;
  endfunction
endmodule